// File: doc/BRIEF.md
# SRAM Sleep-Mode Sequencer

This block controls the way a synchronous SRAM enters and leaves its deep power-down state. The power-down request is an asynchronous pin. The block passes it through a two-flop synchroniser and then counts clock cycles for a fixed entry window and a fixed recovery window. From the first cycle of the entry window until the last cycle of the recovery window, the block holds the data bus in high impedance and stops any address strobe from reaching the access controller. A separate flag marks the true sleep state, during which the array keeps its contents.

If the access controller still has an operation in flight when entry begins, the block raises a one-cycle discard pulse so that the controller drops that operation. A strobe or chip select seen inside either window breaks the interface protocol. Such an event is not forwarded and it sets a sticky error flag, which only reset clears. Once the entry window has started it always runs through to sleep. If the request is withdrawn during entry, the block wakes through the normal recovery window.

Top module: `sram_sleep_seq`

## Requirements
- R1: After reset, `asleep`, `bus_hiz`, `drop_pending` and `proto_err` are all 0.
- R2: While awake (`bus_hiz` = 0), `strobe_p_fwd` equals `strobe_p` and `strobe_c_fwd` equals `strobe_c` in the same cycle.
- R3: A request held high is seen by the sequencer on the 2nd rising edge through the synchroniser. `bus_hiz` rises after the 3rd edge. `asleep` rises ENTRY_CYCLES edges later, which is the 5th edge with the default of 2.
- R4: After the request drops, `asleep` falls after the 3rd edge. `bus_hiz` falls EXIT_CYCLES edges later, which is the 5th edge with the default of 2.
- R5: Both forwarded strobes are 0 whenever `bus_hiz` is 1, whatever values `strobe_p` and `strobe_c` have.
- R6: If `acc_busy` is 1 when entry starts, `drop_pending` is 1 for exactly the first cycle of the entry window.
- R7: If `acc_busy` is 0 when entry starts, `drop_pending` stays 0.
- R8: `proto_err` is set when `strobe_p`, `strobe_c` or `chip_sel` is 1 during the entry or recovery window. It stays set until reset.
- R9: Strobes and chip selects seen while `asleep` is 1 are not forwarded and do not set `proto_err`.
- R10: A request withdrawn during the entry window does not stop entry. `asleep` still rises, then falls on the next edge, and `bus_hiz` falls EXIT_CYCLES edges after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Asynchronous power-down request, active high |
| chip_sel | input | 1 | Combined chip enables active |
| strobe_p | input | 1 | Processor address strobe, active high |
| strobe_c | input | 1 | Controller address strobe, active high |
| acc_busy | input | 1 | Access controller has an operation in flight |
| strobe_p_fwd | output | 1 | Processor strobe passed to the access controller |
| strobe_c_fwd | output | 1 | Controller strobe passed to the access controller |
| bus_hiz | output | 1 | Force the data bus to high impedance |
| asleep | output | 1 | Array is in deep power-down |
| drop_pending | output | 1 | One-cycle pulse: discard the in-flight access |
| proto_err | output | 1 | Sticky: activity seen inside an entry or recovery window |

## Verification
The sleep sequence is driven in four ways: entry with an access in flight, entry while idle, a request withdrawn inside the entry window, and full cycles with strobes or chip selects injected at chosen points. Comparing busy and idle entry shows whether the discard pulse depends on in-flight work. The withdrawn request shows whether entry is committed once it starts. Activity injected while asleep, during entry and during recovery shows whether the design tells a harmless sleeping access apart from a protocol violation. Edge-by-edge sampling around each transition shows whether the synchroniser delay and the two counted windows are off by one.

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic chip_sel,
  input  logic strobe_p,
  input  logic strobe_c,
  input  logic acc_busy,
  output logic strobe_p_fwd,
  output logic strobe_c_fwd,
  output logic bus_hiz,
  output logic asleep,
  output logic drop_pending,
  output logic proto_err
);
  localparam int MAXW  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W = $clog2(MAXW + 1);

  typedef enum logic [1:0] {AWAKE, ENTER, SLEEP, LEAVE} state_t;

  state_t                 state;
  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s;
  logic                   window;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};
  end
  assign req_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= AWAKE;
      cnt   <= '0;
    end else begin
      case (state)
        AWAKE: if (req_s) begin
          state <= ENTER;
          cnt   <= CNT_W'(ENTRY_CYCLES - 1);
        end
        ENTER: if (cnt == '0) state <= SLEEP;
               else           cnt   <= cnt - 1'b1;
        SLEEP: if (!req_s) begin
          state <= LEAVE;
          cnt   <= CNT_W'(EXIT_CYCLES - 1);
        end
        LEAVE: if (cnt == '0) state <= AWAKE;
               else           cnt   <= cnt - 1'b1;
        default: state <= AWAKE;
      endcase
    end
  end

  assign window = (state == ENTER) || (state == LEAVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_pending <= 1'b0;
      proto_err    <= 1'b0;
    end else begin
      drop_pending <= (state == AWAKE) && req_s && acc_busy;
      if (window && (strobe_p || strobe_c || chip_sel)) proto_err <= 1'b1;
    end
  end

  assign bus_hiz      = (state != AWAKE);
  assign asleep       = (state == SLEEP);
  assign strobe_p_fwd = strobe_p && !bus_hiz;
  assign strobe_c_fwd = strobe_c && !bus_hiz;

  // R5
  fwd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hiz |-> !(strobe_p_fwd || strobe_c_fwd));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R6
  drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pending |=> !drop_pending);

  // R3
  sleep_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(bus_hiz));

  // R4
  wake_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hiz) |-> $past(!asleep));

  // R3
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> bus_hiz);
endmodule

// File: tb/sram_sleep_seq_bench.sv
module sram_sleep_seq_bench;
  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, chip_sel = 0, strobe_p = 0, strobe_c = 0, acc_busy = 0;
  logic strobe_p_fwd, strobe_c_fwd, bus_hiz, asleep, drop_pending, proto_err;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sram_sleep_seq u_sram_sleep_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
    .strobe_p(strobe_p), .strobe_c(strobe_c), .acc_busy(acc_busy),
    .strobe_p_fwd(strobe_p_fwd), .strobe_c_fwd(strobe_c_fwd),
    .bus_hiz(bus_hiz), .asleep(asleep), .drop_pending(drop_pending),
    .proto_err(proto_err));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; sleep_req = 0; chip_sel = 0; strobe_p = 0; strobe_c = 0; acc_busy = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 asleep", asleep, 0);
    check("R1 bus_hiz", bus_hiz, 0);
    check("R1 drop_pending", drop_pending, 0);
    check("R1 proto_err", proto_err, 0);
  endtask

  task automatic t_forward;
    strobe_p = 1; #1;
    check("R2 p fwd", strobe_p_fwd, 1);
    check("R2 c idle", strobe_c_fwd, 0);
    strobe_p = 0; strobe_c = 1; #1;
    check("R2 c fwd", strobe_c_fwd, 1);
    check("R2 p idle", strobe_p_fwd, 0);
    strobe_c = 0;
  endtask

  task automatic t_entry_busy;
    do_reset();
    acc_busy = 1; sleep_req = 1;
    step(2);
    check("R3 hiz not yet", bus_hiz, 0);
    step(1);
    check("R3 hiz up", bus_hiz, 1);
    check("R6 drop pulse", drop_pending, 1);
    step(1);
    check("R6 drop one cycle", drop_pending, 0);
    check("R3 not yet asleep", asleep, 0);
    step(1);
    check("R3 asleep", asleep, 1);
    acc_busy = 0;
    strobe_p = 1; strobe_c = 1; chip_sel = 1; #1;
    check("R9 p blocked", strobe_p_fwd, 0);
    check("R5 c blocked", strobe_c_fwd, 0);
    step(1);
    check("R9 no err asleep", proto_err, 0);
    strobe_p = 0; strobe_c = 0; chip_sel = 0;
    sleep_req = 0;
    step(2);
    check("R4 still asleep", asleep, 1);
    step(1);
    check("R4 awake flag", asleep, 0);
    check("R4 hiz held", bus_hiz, 1);
    step(1);
    check("R4 hiz held 2", bus_hiz, 1);
    step(1);
    check("R4 hiz down", bus_hiz, 0);
    check("R8 no err clean", proto_err, 0);
  endtask

  task automatic t_entry_idle;
    do_reset();
    sleep_req = 1;
    step(3);
    check("R7 no drop", drop_pending, 0);
    step(1);
    check("R7 no drop later", drop_pending, 0);
    step(1);
    check("R3 asleep idle", asleep, 1);
    sleep_req = 0;
    step(5);
    check("R4 awake idle", bus_hiz, 0);
  endtask

  task automatic t_entry_violation;
    do_reset();
    sleep_req = 1;
    step(3);
    strobe_c = 1; #1;
    check("R5 c blocked entry", strobe_c_fwd, 0);
    step(1);
    strobe_c = 0;
    check("R8 err on entry", proto_err, 1);
    step(1);
    check("R3 asleep after err", asleep, 1);
    sleep_req = 0;
    step(5);
    check("R8 err sticky", proto_err, 1);
    strobe_p = 1; #1;
    check("R2 fwd after wake", strobe_p_fwd, 1);
    strobe_p = 0;
    do_reset();
    check("R8 reset clears err", proto_err, 0);
  endtask

  task automatic t_exit_violation;
    do_reset();
    sleep_req = 1;
    step(5);
    sleep_req = 0;
    step(3);
    check("R4 in recovery", bus_hiz, 1);
    chip_sel = 1;
    step(1);
    chip_sel = 0;
    check("R8 err on recovery", proto_err, 1);
  endtask

  task automatic t_withdraw;
    do_reset();
    sleep_req = 1;
    step(3);
    check("R10 entry started", bus_hiz, 1);
    sleep_req = 0;
    step(2);
    check("R10 asleep anyway", asleep, 1);
    step(1);
    check("R10 leaves sleep", asleep, 0);
    check("R10 hiz held", bus_hiz, 1);
    step(2);
    check("R10 awake", bus_hiz, 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_entry_busy();
        t_entry_idle();
        t_entry_violation();
        t_exit_violation();
        t_withdraw();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule